// File: doc/BRIEF.md
# Status Byte and Service Request Logic

This block is the status-summary core of a programmable instrument. It keeps a standard event register that latches communication-related events and a power-on event. It also keeps an enable mask for that register, and the OR of the enabled events forms an event summary bit. That bit is combined with the summary bits of the other status groups (including the questionable group) into a status byte. A service request enable mask, applied to the status byte, gives the master summary. A rising master summary sets a request-service flag, and the service request line is driven from that flag.

Three read strobes reach the block: a destructive read of the standard event register, a serial poll of the status byte, and a non-destructive status byte query. Each read puts one byte on `readData` on the following clock, with a one-cycle `readValid`. The query returns the master summary in bit 6 and clears nothing. A serial poll returns the request-service flag in bit 6 and clears that flag. A power-up strobe sets the power-on event. When the power-on clear option is on, the same strobe also wipes both enable masks. When the option is off, the masks keep their values, which lets a unit that lost power raise a service request when it comes back.

Top module: `stb_srq_unit`

## Requirements
- R1: After `rstN` is released, `readData` is 0x00, `readValid` is 0 and `srq` is 0, and every internal register is zero.
- R2: A 1 on bit i of `stdEventSet` sets bit i of the standard event register, which holds until read. A read (`stdEventRd`) returns the register on `readData` one cycle later and clears it. An event arriving in the same cycle as the read survives into the cleared register.
- R3: A `powerUp` strobe sets bit 7 (power-on) of the standard event register.
- R4: On `powerUp` with `pwrClrOn`=1, both enable masks are cleared. With `pwrClrOn`=0, both are kept.
- R5: Status byte bit 5 is the OR of the standard event register ANDed with its enable mask.
- R6: Status byte bits 0 to 4 follow `grpSum[4:0]` (bit 3 is the questionable summary), and bit 7 follows `operSum`.
- R7: The master summary is the OR of status byte bits 0 to 5 and 7, each ANDed with the matching service request enable bit. Enable bit 6 has no effect.
- R8: A `stbQuery` returns the status byte with the master summary in bit 6 one cycle later. It changes neither `srq` nor the standard event register.
- R9: A rising edge of the master summary sets the request-service flag on the next clock. `srq` is high while the flag is set, even after the master summary falls.
- R10: A `serialPoll` returns the status byte with the request-service flag in bit 6 one cycle later and clears the flag, unless the master summary rises in that same cycle.
- R11: When several read strobes arrive together, only one is served, in the order event register read, then serial poll, then query. Strobes that are not served have no effect.
- R12: With `pwrClrOn`=0, an event enable of 0x80 and a service request enable of 0x20, a `powerUp` strobe raises `srq` two cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| powerUp | input | 1 | One-cycle power-up strobe |
| pwrClrOn | input | 1 | Power-on clear option for the enable masks |
| stdEventSet | input | 8 | Event pulses into the standard event register |
| eseWr | input | 1 | Write strobe, standard event enable mask |
| eseWrData | input | 8 | Value for the standard event enable mask |
| sreWr | input | 1 | Write strobe, service request enable mask |
| sreWrData | input | 8 | Value for the service request enable mask |
| grpSum | input | 5 | Summary bits for status byte bits 0 to 4 |
| operSum | input | 1 | Summary bit for status byte bit 7 |
| stbQuery | input | 1 | Non-destructive status byte query strobe |
| serialPoll | input | 1 | Serial poll strobe |
| stdEventRd | input | 1 | Destructive read strobe of the standard event register |
| readData | output | 8 | Byte returned by the last read |
| readValid | output | 1 | High for one cycle when readData is updated |
| srq | output | 1 | Service request line |

## Verification
The bench checks the two status byte reads against each other while the request flag and the master summary disagree. A design that swapped them, or that let the query clear the flag, would return the wrong bit 6 or drop `srq`. It checks an event that lands in the same cycle as a register read; a design that cleared after merging would lose it. It sends a read strobe and a poll together to confirm the poll is not served and the flag survives. It runs power-up with the clear option both off and on, so that a design that always kept or always wiped the masks fails either the service request scenario or the later query.

// File: rtl/stb_pkg.sv
package stb_pkg;
  localparam int STB_W   = 8;
  localparam int ESB_BIT = 5;
  localparam int MSS_BIT = 6;
  localparam int PON_BIT = 7;

  typedef enum logic [1:0] {
    RD_NONE  = 2'd0,
    RD_ESR   = 2'd1,
    RD_POLL  = 2'd2,
    RD_QUERY = 2'd3
  } rdSel_t;

  typedef struct packed {
    rdSel_t rdSel;
    logic   esrClr;
    logic   ponSet;
    logic   enaClr;
  } ctrlStrobe_t;
endpackage

// File: rtl/stb_ctrl.sv
module stb_ctrl
  import stb_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        powerUp,
  input  logic        pwrClrOn,
  input  logic        stbQuery,
  input  logic        serialPoll,
  input  logic        stdEventRd,
  input  logic        mss,
  output ctrlStrobe_t strobes,
  output logic        rqs
);
  logic mssPrev;
  logic mssRise;
  logic pollAct;

  // one read served per cycle: event register, then poll, then query
  always_comb begin
    strobes = '0;
    if (stdEventRd)      strobes.rdSel = RD_ESR;
    else if (serialPoll) strobes.rdSel = RD_POLL;
    else if (stbQuery)   strobes.rdSel = RD_QUERY;
    else                 strobes.rdSel = RD_NONE;
    strobes.esrClr = stdEventRd;
    strobes.ponSet = powerUp;
    strobes.enaClr = powerUp & pwrClrOn;
  end

  assign mssRise = mss & ~mssPrev;
  assign pollAct = (strobes.rdSel == RD_POLL);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mssPrev <= 1'b0;
      rqs     <= 1'b0;
    end else begin
      mssPrev <= mss;
      rqs     <= (rqs & ~pollAct) | mssRise;
    end
  end

  AST_RQS_ON_RISE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mss) |=> rqs); // R9
  AST_POLL_CLEARS_RQS: assert property (@(posedge clk) disable iff (!rstN)
    (serialPoll && !stdEventRd && !$rose(mss)) |=> !rqs); // R10
  AST_QUERY_KEEPS_RQS: assert property (@(posedge clk) disable iff (!rstN)
    (stbQuery && !serialPoll && !$rose(mss)) |=> (rqs == $past(rqs))); // R8
  AST_ESR_WINS_OVER_POLL: assert property (@(posedge clk) disable iff (!rstN)
    (stdEventRd && serialPoll && rqs) |=> rqs); // R11
endmodule

// File: rtl/stb_datapath.sv
module stb_datapath
  import stb_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strobes,
  input  logic             rqs,
  input  logic [STB_W-1:0] stdEventSet,
  input  logic             eseWr,
  input  logic [STB_W-1:0] eseWrData,
  input  logic             sreWr,
  input  logic [STB_W-1:0] sreWrData,
  input  logic [4:0]       grpSum,
  input  logic             operSum,
  output logic             mss,
  output logic [STB_W-1:0] readData,
  output logic             readValid
);
  localparam logic [STB_W-1:0] MSS_MASK = ~(STB_W'(1) << MSS_BIT);

  logic [STB_W-1:0] esr;
  logic [STB_W-1:0] ese;
  logic [STB_W-1:0] sre;
  logic [STB_W-1:0] stbCore;
  logic             esb;

  // per-bit latch of the standard event register
  for (genvar i = 0; i < STB_W; i++) begin : g_esr
    logic setBit;
    if (i == PON_BIT) begin : g_pon
      assign setBit = stdEventSet[i] | strobes.ponSet;
    end else begin : g_plain
      assign setBit = stdEventSet[i];
    end
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) esr[i] <= 1'b0;
      else       esr[i] <= (esr[i] & ~strobes.esrClr) | setBit;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ese <= '0;
      sre <= '0;
    end else begin
      if (eseWr)              ese <= eseWrData;
      else if (strobes.enaClr) ese <= '0;
      if (sreWr)              sre <= sreWrData;
      else if (strobes.enaClr) sre <= '0;
    end
  end

  assign esb     = |(esr & ese);
  assign stbCore = {operSum, 1'b0, esb, grpSum};
  assign mss     = |(stbCore & sre & MSS_MASK);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readData  <= '0;
      readValid <= 1'b0;
    end else begin
      readValid <= (strobes.rdSel != RD_NONE);
      unique case (strobes.rdSel)
        RD_ESR:   readData <= esr;
        RD_POLL:  readData <= {stbCore[7], rqs, stbCore[5:0]};
        RD_QUERY: readData <= {stbCore[7], mss, stbCore[5:0]};
        default:  readData <= readData;
      endcase
    end
  end

  AST_PON_SETS_BIT7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.ponSet |=> esr[PON_BIT]); // R3
  AST_ESR_READ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.esrClr && stdEventSet == '0 && !strobes.ponSet) |=> (esr == '0)); // R2
  AST_ENABLE_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.ponSet && !strobes.enaClr && !eseWr && !sreWr)
      |=> (ese == $past(ese) && sre == $past(sre))); // R4
  AST_ENABLE_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.enaClr && !eseWr && !sreWr) |=> (ese == '0 && sre == '0)); // R4
  AST_READ_VALID: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.rdSel != RD_NONE) |=> readValid); // R8
endmodule

// File: rtl/stb_srq_unit.sv
module stb_srq_unit
  import stb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       powerUp,
  input  logic       pwrClrOn,
  input  logic [7:0] stdEventSet,
  input  logic       eseWr,
  input  logic [7:0] eseWrData,
  input  logic       sreWr,
  input  logic [7:0] sreWrData,
  input  logic [4:0] grpSum,
  input  logic       operSum,
  input  logic       stbQuery,
  input  logic       serialPoll,
  input  logic       stdEventRd,
  output logic [7:0] readData,
  output logic       readValid,
  output logic       srq
);
  ctrlStrobe_t strobes;
  logic        rqs;
  logic        mss;

  stb_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .powerUp    (powerUp),
    .pwrClrOn   (pwrClrOn),
    .stbQuery   (stbQuery),
    .serialPoll (serialPoll),
    .stdEventRd (stdEventRd),
    .mss        (mss),
    .strobes    (strobes),
    .rqs        (rqs)
  );

  stb_datapath i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .rqs         (rqs),
    .stdEventSet (stdEventSet),
    .eseWr       (eseWr),
    .eseWrData   (eseWrData),
    .sreWr       (sreWr),
    .sreWrData   (sreWrData),
    .grpSum      (grpSum),
    .operSum     (operSum),
    .mss         (mss),
    .readData    (readData),
    .readValid   (readValid)
  );

  assign srq = rqs;

  AST_SRQ_AFTER_PON: assert property (@(posedge clk) disable iff (!rstN)
    (srq && !serialPoll) |=> srq); // R9
endmodule

// File: tb/test_stb_srq_unit.sv
module test_stb_srq_unit;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       powerUp = 1'b0;
  logic       pwrClrOn = 1'b0;
  logic [7:0] stdEventSet = '0;
  logic       eseWr = 1'b0;
  logic [7:0] eseWrData = '0;
  logic       sreWr = 1'b0;
  logic [7:0] sreWrData = '0;
  logic [4:0] grpSum = '0;
  logic       operSum = 1'b0;
  logic       stbQuery = 1'b0;
  logic       serialPoll = 1'b0;
  logic       stdEventRd = 1'b0;
  logic [7:0] readData;
  logic       readValid;
  logic       srq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  stb_srq_unit i_stb_srq_unit (
    .clk(clk), .rstN(rstN), .powerUp(powerUp), .pwrClrOn(pwrClrOn),
    .stdEventSet(stdEventSet), .eseWr(eseWr), .eseWrData(eseWrData),
    .sreWr(sreWr), .sreWrData(sreWrData), .grpSum(grpSum), .operSum(operSum),
    .stbQuery(stbQuery), .serialPoll(serialPoll), .stdEventRd(stdEventRd),
    .readData(readData), .readValid(readValid), .srq(srq)
  );

  // {status summary inputs (bits 5,6 zero), service request enable, expected query}
  localparam int NVEC = 7;
  localparam logic [23:0] VEC [NVEC] = '{
    {8'h08, 8'h08, 8'h48},
    {8'h08, 8'h00, 8'h08},
    {8'h80, 8'h80, 8'hC0},
    {8'h00, 8'hFF, 8'h00},
    {8'h17, 8'h40, 8'h17},
    {8'h81, 8'h01, 8'hC1},
    {8'h04, 8'h02, 8'h04}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic setSum(input logic [7:0] v);
    grpSum  = v[4:0];
    operSum = v[7];
  endtask

  task automatic wrEse(input logic [7:0] v);
    @(negedge clk); eseWr = 1'b1; eseWrData = v;
    @(negedge clk); eseWr = 1'b0;
  endtask

  task automatic wrSre(input logic [7:0] v);
    @(negedge clk); sreWr = 1'b1; sreWrData = v;
    @(negedge clk); sreWr = 1'b0;
  endtask

  task automatic event8(input logic [7:0] v);
    @(negedge clk); stdEventSet = v;
    @(negedge clk); stdEventSet = '0;
  endtask

  task automatic doQuery();
    @(negedge clk); stbQuery = 1'b1;
    @(negedge clk); stbQuery = 1'b0;
  endtask

  task automatic doPoll();
    @(negedge clk); serialPoll = 1'b1;
    @(negedge clk); serialPoll = 1'b0;
  endtask

  task automatic doEsrRd();
    @(negedge clk); stdEventRd = 1'b1;
    @(negedge clk); stdEventRd = 1'b0;
  endtask

  task automatic doPowerUp(input logic clrOpt);
    @(negedge clk); pwrClrOn = clrOpt; powerUp = 1'b1;
    @(negedge clk); powerUp = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    idle();
    // R1 reset state
    check("R1 readData", readData, 8'h00);
    check("R1 readValid", {7'd0, readValid}, 8'h00);
    check("R1 srq", {7'd0, srq}, 8'h00);

    // R6 R7 R8 table walk
    for (int k = 0; k < NVEC; k++) begin
      setSum(VEC[k][23:16]);
      wrSre(VEC[k][15:8]);
      doQuery();
      check("R6/R7/R8 query", readData, VEC[k][7:0]);
      check("R8 readValid", {7'd0, readValid}, 8'h01);
    end
    setSum(8'h00);
    wrSre(8'h00);
    doPoll();
    check("R10 poll clears srq", {7'd0, srq}, 8'h00);

    // R2 standard event register
    event8(8'h05);
    doEsrRd();
    check("R2 read contents", readData, 8'h05);
    doEsrRd();
    check("R2 cleared by read", readData, 8'h00);
    event8(8'h01);
    @(negedge clk); stdEventRd = 1'b1; stdEventSet = 8'h02;
    @(negedge clk); stdEventRd = 1'b0; stdEventSet = 8'h00;
    check("R2 read with new event", readData, 8'h01);
    doEsrRd();
    check("R2 new event kept", readData, 8'h02);

    // R5 event summary bit
    wrEse(8'h04);
    event8(8'h04);
    doQuery();
    check("R5 summary bit", readData, 8'h20);
    check("R5 no request", {7'd0, srq}, 8'h00);

    // R9 R10 R8 poll versus query
    wrSre(8'h20);
    idle();
    check("R9 srq set", {7'd0, srq}, 8'h01);
    doPoll();
    check("R10 poll bit6", readData, 8'h60);
    check("R10 srq cleared", {7'd0, srq}, 8'h00);
    doQuery();
    check("R8 query mss", readData, 8'h60);
    check("R8 srq untouched", {7'd0, srq}, 8'h00);
    doPoll();
    check("R10 poll flag clear", readData, 8'h20);

    // R11 priority, R9 flag holds after mss falls
    doEsrRd();
    check("R2 read 04", readData, 8'h04);
    event8(8'h04);
    idle();
    check("R9 srq on rise", {7'd0, srq}, 8'h01);
    @(negedge clk); stdEventRd = 1'b1; serialPoll = 1'b1;
    @(negedge clk); stdEventRd = 1'b0; serialPoll = 1'b0;
    check("R11 event read wins", readData, 8'h04);
    check("R11 poll not served", {7'd0, srq}, 8'h01);
    doPoll();
    check("R10 poll with flag", readData, 8'h40);
    check("R10 srq low", {7'd0, srq}, 8'h00);

    // R12 R3 R4 power-up, option off
    wrEse(8'h80);
    wrSre(8'h20);
    doPowerUp(1'b0);
    idle();
    check("R12 srq after power-up", {7'd0, srq}, 8'h01);
    doEsrRd();
    check("R3 power-on bit", readData, 8'h80);
    doPoll();
    check("R4 masks kept poll", readData, 8'h40);

    // R4 option on
    doPowerUp(1'b1);
    idle();
    check("R4 no srq when cleared", {7'd0, srq}, 8'h00);
    doQuery();
    check("R4 event enable cleared", readData, 8'h00);
    wrEse(8'h80);
    doQuery();
    check("R4 request enable cleared", readData, 8'h20);
    doEsrRd();
    check("R3 power-on bit again", readData, 8'h80);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule